// File: doc/BRIEF.md
# Real-Time Clock CMOS Register Port

This block is the register-access front end of a real-time clock with battery-backed CMOS memory. Software sees two banks of 128 bytes. Each bank has its own pair of ports: an index port that holds an address, and a data port that reads or writes the byte at that address. All four ports share one request interface. A request names the port on `req_sel` and says on `req_write` whether it is a read or a write.

The primary index port has a second job. The top bit of any byte written to it drives the `nmi_mask` output, and only the lower seven bits form the address. Primary byte 0x0C is a status byte held apart from the storage array. Reading it returns its value and clears it. When an update event arrives on `update_tick` while the update-interrupt enable in byte 0x0B is set, the status byte records an update-ended flag and `rtc_irq` rises. Calendar arithmetic, alarms, the periodic interrupt and the square-wave output belong to other blocks.

A small access sequencer has two states:
- `ST_IDLE`: no read result is pending.
- `ST_RESP`: the read result is on `rd_data` and `rd_valid` is high.

The transitions are:
- `IDLE->RESP` and `RESP->RESP`: a read request is accepted.
- `RESP->IDLE` and `IDLE->IDLE`: any other cycle.

Top module: `rtc_cmos_port`

## Requirements
- R1: A write to port select 0 (primary index) stores data bit 7 on `nmi_mask` and data bits 6:0 as the primary address, both visible from the next cycle.
- R2: A read or write on port select 1 (primary data) accesses the primary byte at the stored address. A read returns its byte on `rd_data` in the next cycle, with `rd_valid` high for that one cycle (state `ST_RESP`).
- R3: A write to port select 2 (secondary index) stores all 8 bits as the secondary address. When that address is below 128, port select 3 (secondary data) reads and writes the secondary byte at it.
- R4: When the secondary address is 128 or above, a read on port select 3 returns 0xFF and a write there changes no byte.
- R5: A read of either index port (select 0 or 2) returns 0x00.
- R6: A read of primary address 0x0C returns the status byte as it was, then clears the status byte to 0x00. Writes to primary address 0x0C are ignored.
- R7: An `update_tick` pulse while bit 4 of primary byte 0x0B is set sets bit 4 (update-ended) and bit 7 (interrupt pending) of the status byte. The enable value used is the one held before that clock edge. With the enable clear, the tick changes nothing.
- R8: `rtc_irq` is high exactly while status bit 4 is set and falls the cycle after the status byte is read. If a tick arrives in the same cycle as that read, the tick wins: the read returns the old value and the flag stays set.
- R9: After reset, every byte of both banks, both addresses, `nmi_mask`, `rtc_irq` and `rd_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 primary index, 1 primary data, 2 secondary index, 3 secondary data |
| req_wdata | input | 8 | Write data |
| update_tick | input | 1 | One-cycle update-ended event |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | High the cycle after a read request |
| nmi_mask | output | 1 | Non-maskable-interrupt mask |
| rtc_irq | output | 1 | Update interrupt request |

## Verification
A corrupted address register shows up on the very next data read as a byte from the wrong location, or, on the secondary side, as a spurious 0xFF. A stale enable mirror or status byte appears on `rtc_irq` one cycle after the tick or the clearing read that should have changed it. The random mix keeps pointing the index at 0x0B and 0x0C and lands ticks on the same cycle as status reads, so these mismatches surface within a few accesses.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

    localparam int BYTE_W      = 8;
    localparam int ADDR_W      = 7;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = 7'h0C;
    localparam logic [ADDR_W-1:0] CTRL_ADDR   = 7'h0B;
    localparam int UIE_BIT     = 4;
    localparam int UF_BIT      = 4;
    localparam int IRQF_BIT    = 7;

    typedef enum logic [1:0] {
        SEL_PRI_IDX = 2'd0,
        SEL_PRI_DAT = 2'd1,
        SEL_SEC_IDX = 2'd2,
        SEL_SEC_DAT = 2'd3
    } port_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

endpackage

// File: rtl/rtc_bank.sv
module rtc_bank #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/rtc_index.sv
module rtc_index
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_we,
    input  logic              sec_we,
    input  logic [BYTE_W-1:0] wdata,
    output logic [ADDR_W-1:0] pri_addr,
    output logic [ADDR_W:0]   sec_addr,
    output logic              nmi_mask
);
    localparam int NMI_BIT = BYTE_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_addr <= '0;
            nmi_mask <= 1'b0;
        end else if (pri_we) begin
            pri_addr <= wdata[ADDR_W-1:0];
            nmi_mask <= wdata[NMI_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_addr <= '0;
        end else if (sec_we) begin
            sec_addr <= wdata[ADDR_W:0];
        end
    end

    p_nmi_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pri_we |=> (nmi_mask == $past(wdata[NMI_BIT])));

    p_addr_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pri_we |=> (pri_addr == $past(wdata[ADDR_W-1:0])));

endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    input  logic              tick,
    input  logic              rd_clear,
    output logic [BYTE_W-1:0] status_q,
    output logic              uf_flag
);
    logic              uie_q;
    logic [BYTE_W-1:0] status_d;
    logic [BYTE_W-1:0] set_mask;

    always_comb begin
        set_mask           = '0;
        set_mask[UF_BIT]   = 1'b1;
        set_mask[IRQF_BIT] = 1'b1;
    end

    // Enable mirror follows writes to the control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uie_q <= 1'b0;
        end else if (ctrl_we) begin
            uie_q <= ctrl_wdata[UIE_BIT];
        end
    end

    // Clear first, then the set from a tick, so a same-cycle tick wins
    always_comb begin
        status_d = status_q;
        if (rd_clear) begin
            status_d = '0;
        end
        if (tick && uie_q) begin
            status_d = status_d | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign uf_flag = status_q[UF_BIT];

    p_uf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && uie_q) |=> (status_q[UF_BIT] && status_q[IRQF_BIT]));

    p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[UF_BIT]) |-> $past(tick && uie_q));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !tick) |=> (status_q == '0));

endmodule

// File: rtl/rtc_cmos_port.sv
module rtc_cmos_port
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sel,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic              update_tick,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              nmi_mask,
    output logic              rtc_irq
);
    localparam logic [BYTE_W-1:0] OOB_BYTE = '1;

    port_sel_e         sel;
    acc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pri_addr;
    logic [ADDR_W:0]   sec_addr;
    logic [BYTE_W-1:0] pri_rdata, sec_rdata, status_byte, rd_next;
    logic              wr_req, rd_req;
    logic              pri_idx_we, sec_idx_we;
    logic              pri_dat_acc, sec_dat_acc;
    logic              hit_status, sec_in_range;
    logic              pri_bank_we, sec_bank_we, ctrl_we, rd_clear;
    logic              uf_flag;

    assign sel          = port_sel_e'(req_sel);
    assign wr_req       = req_valid && req_write;
    assign rd_req       = req_valid && !req_write;
    assign pri_idx_we   = wr_req && (sel == SEL_PRI_IDX);
    assign sec_idx_we   = wr_req && (sel == SEL_SEC_IDX);
    assign pri_dat_acc  = req_valid && (sel == SEL_PRI_DAT);
    assign sec_dat_acc  = req_valid && (sel == SEL_SEC_DAT);
    assign hit_status   = (pri_addr == STATUS_ADDR);
    assign sec_in_range = !sec_addr[ADDR_W];
    assign pri_bank_we  = pri_dat_acc && req_write && !hit_status;
    assign sec_bank_we  = sec_dat_acc && req_write && sec_in_range;
    assign ctrl_we      = pri_dat_acc && req_write && (pri_addr == CTRL_ADDR);
    assign rd_clear     = pri_dat_acc && !req_write && hit_status;

    rtc_index u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .pri_we   (pri_idx_we),
        .sec_we   (sec_idx_we),
        .wdata    (req_wdata),
        .pri_addr (pri_addr),
        .sec_addr (sec_addr),
        .nmi_mask (nmi_mask)
    );

    rtc_bank #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_pri_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pri_bank_we),
        .addr  (pri_addr),
        .wdata (req_wdata),
        .rdata (pri_rdata)
    );

    rtc_bank #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_sec_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sec_bank_we),
        .addr  (sec_addr[ADDR_W-1:0]),
        .wdata (req_wdata),
        .rdata (sec_rdata)
    );

    rtc_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (req_wdata),
        .tick       (update_tick),
        .rd_clear   (rd_clear),
        .status_q   (status_byte),
        .uf_flag    (uf_flag)
    );

    // Read data selection by port
    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_PRI_IDX: rd_next = '0;
            SEL_SEC_IDX: rd_next = '0;
            SEL_PRI_DAT: rd_next = hit_status ? status_byte : pri_rdata;
            SEL_SEC_DAT: rd_next = sec_in_range ? sec_rdata : OOB_BYTE;
        endcase
    end

    // Access sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= rd_next;
        end
    end

    assign rd_valid = (state_q == ST_RESP);
    assign rtc_irq  = uf_flag;

    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    p_rvalid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    p_idx_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (sel == SEL_PRI_IDX || sel == SEL_SEC_IDX)) |=> (rd_data == '0));

    p_sec_oob_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel == SEL_SEC_DAT && sec_addr[ADDR_W]) |=> (rd_data == OOB_BYTE));

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && !update_tick) |=> !rtc_irq);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_irq && !rd_clear) |=> rtc_irq);

endmodule

// File: tb/sim_rtc_cmos_port.sv
module sim_rtc_cmos_port;

    localparam time CLK_HALF = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_sel = 2'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       update_tick = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       nmi_mask;
    logic       rtc_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] pm [128];
    logic [7:0] sm [128];
    logic [6:0] m_pidx;
    logic [7:0] m_sidx;
    logic       m_nmi;
    logic [7:0] m_stat;

    rtc_cmos_port u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_sel     (req_sel),
        .req_wdata   (req_wdata),
        .update_tick (update_tick),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .nmi_mask    (nmi_mask),
        .rtc_irq     (rtc_irq)
    );

    always #CLK_HALF clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [1:0] sel);
        case (sel)
            2'd1:    return (m_pidx == 7'h0C) ? m_stat : pm[m_pidx];
            2'd3:    return m_sidx[7] ? 8'hFF : sm[m_sidx[6:0]];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return "R5 primary index read";
            2'd1:    return (m_pidx == 7'h0C) ? "R6 status read" : "R2 primary data read";
            2'd2:    return "R5 secondary index read";
            default: return m_sidx[7] ? "R4 secondary out-of-range read" : "R3 secondary data read";
        endcase
    endfunction

    task automatic model_update(input logic wr, input logic [1:0] sel,
                                input logic [7:0] d, input logic tk);
        logic uie_old;
        uie_old = pm[7'h0B][4];
        if (wr) begin
            case (sel)
                2'd0: begin m_nmi = d[7]; m_pidx = d[6:0]; end
                2'd1: if (m_pidx != 7'h0C) pm[m_pidx] = d;
                2'd2: m_sidx = d;
                default: if (!m_sidx[7]) sm[m_sidx[6:0]] = d;
            endcase
        end else if (sel == 2'd1 && m_pidx == 7'h0C) begin
            m_stat = 8'h00;
        end
        if (tk && uie_old) m_stat = m_stat | 8'h90;
    endtask

    task automatic op(input logic wr, input logic [1:0] sel,
                      input logic [7:0] d, input logic tk);
        logic [7:0] exp;
        string      rq;
        @(negedge clk);
        req_valid   = 1'b1;
        req_write   = wr;
        req_sel     = sel;
        req_wdata   = d;
        update_tick = tk;
        exp = model_read(sel);
        rq  = req_of(sel);
        model_update(wr, sel, d, tk);
        @(negedge clk);
        req_valid   = 1'b0;
        update_tick = 1'b0;
        if (!wr) begin
            chk("R2 rd_valid after read", {7'd0, rd_valid}, 8'd1);
            chk(rq, rd_data, exp);
        end else begin
            chk("R2 rd_valid idle after write", {7'd0, rd_valid}, 8'd0);
        end
        chk("R1 nmi_mask", {7'd0, nmi_mask}, {7'd0, m_nmi});
        chk("R8 rtc_irq follows flag", {7'd0, rtc_irq}, {7'd0, m_stat[4]});
    endtask

    initial begin
        #(CLK_HALF * 2 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R2: actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) begin
            pm[i] = 8'h00;
            sm[i] = 8'h00;
        end
        m_pidx = '0; m_sidx = '0; m_nmi = 1'b0; m_stat = '0;
        void'($urandom(32'h0000_5EED));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset rd_valid", {7'd0, rd_valid}, 8'd0);
        chk("R9 reset nmi_mask", {7'd0, nmi_mask}, 8'd0);
        chk("R9 reset rtc_irq", {7'd0, rtc_irq}, 8'd0);
        op(1'b0, 2'd1, 8'h00, 1'b0);           // R9 primary byte 0 reads 0
        op(1'b0, 2'd3, 8'h00, 1'b0);           // R9 secondary byte 0 reads 0

        // R1: top bit to NMI mask, low bits to address
        op(1'b1, 2'd0, 8'hA5, 1'b0);
        op(1'b1, 2'd1, 8'h3C, 1'b0);
        op(1'b1, 2'd0, 8'h25, 1'b0);
        op(1'b0, 2'd1, 8'h00, 1'b0);           // R2 same byte via other index value
        // R5 index reads
        op(1'b0, 2'd0, 8'h00, 1'b0);
        op(1'b0, 2'd2, 8'h00, 1'b0);
        // R3 / R4 secondary bank
        op(1'b1, 2'd2, 8'h05, 1'b0);
        op(1'b1, 2'd3, 8'h77, 1'b0);
        op(1'b1, 2'd2, 8'h85, 1'b0);
        op(1'b1, 2'd3, 8'h11, 1'b0);           // R4 ignored
        op(1'b0, 2'd3, 8'h00, 1'b0);           // R4 reads FF
        op(1'b1, 2'd2, 8'h05, 1'b0);
        op(1'b0, 2'd3, 8'h00, 1'b0);           // R4 byte 5 still 77
        // R7 tick without enable
        op(1'b1, 2'd0, 8'h0C, 1'b1);
        op(1'b0, 2'd1, 8'h00, 1'b0);
        // R7 enable, tick, R6/R8 clear
        op(1'b1, 2'd0, 8'h0B, 1'b0);
        op(1'b1, 2'd1, 8'h10, 1'b0);
        op(1'b1, 2'd0, 8'h0C, 1'b1);
        op(1'b1, 2'd1, 8'h00, 1'b0);           // R6 write to status ignored
        op(1'b0, 2'd1, 8'h00, 1'b0);           // R6 returns 90, clears
        op(1'b0, 2'd1, 8'h00, 1'b0);           // R6 now 00
        // R8 tick in same cycle as the status read
        op(1'b0, 2'd1, 8'h00, 1'b1);
        op(1'b0, 2'd1, 8'h00, 1'b1);
        op(1'b0, 2'd1, 8'h00, 1'b0);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic       wr;
            logic [1:0] sel;
            logic [7:0] d;
            logic       tk;
            wr  = ($urandom % 2) == 0;
            sel = 2'($urandom % 4);
            d   = 8'($urandom);
            if (sel == 2'd0 && ($urandom % 3) != 0) begin
                case ($urandom % 4)
                    0: d = 8'h0B;
                    1: d = 8'h0C;
                    2: d = 8'h8C;
                    default: d = 8'h8B;
                endcase
            end
            if (sel == 2'd1 && wr && ($urandom % 2) == 0) d = 8'h10;
            tk = ($urandom % 5) == 0;
            op(wr, sel, d, tk);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule